// File: doc/BRIEF.md
# Stride Detecting Line Prefetcher

This block watches demand misses arriving at a second-level cache and proposes lines worth fetching early. Every miss carries a line address (byte address divided by the 64-byte line size) and a stream number. The stream number selects one entry of a small history table. That entry records the stream's previous line, the previous line-to-line delta and a two-bit confidence counter.

While a stream shows no steady pattern, a miss on line X yields a single request for line X+1. Once the same nonzero delta has repeated often enough, the stream is treated as strided. A miss then yields a short burst of requests X+d, X+2d, and so on, up to a look-ahead depth.

Requests leave on a valid/ready port, one per cycle. The block counts requests that have been accepted but not yet completed, and it stops offering new requests while that count sits at the cap. A request equal to the one most recently accepted is dropped instead of being offered again. A new miss always replaces whatever part of the previous burst has not yet been issued.

Top module: `stride_prefetcher`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pfValid` is low; the outstanding count starts at zero.
- R2: A miss on a stream whose confidence after the update is below 2 queues exactly one request, for line X+1.
- R3: On each miss the confidence of that stream becomes min(old+1, 3) when the entry already holds a delta and the new nonzero delta equals it; otherwise it becomes 0. The first miss of a stream stores a delta of 0.
- R4: A miss whose updated confidence is 2 or more queues the lines X+k·d for k = 1..DEGREE in increasing k, where d is that miss's delta. The first request is offered in the cycle after the miss, and at most one request is issued per cycle.
- R5: A zero delta never produces a strided burst: it resets confidence to 0 and falls back to the X+1 request.
- R6: `pfValid` stays low whenever CAP requests are outstanding. A request becomes outstanding when `pfValid` and `pfReady` are both high. A `pfDone` pulse retires one request, and it has no effect when none is outstanding.
- R7: A queued line equal to the most recently accepted request is discarded without being offered. Discarding it takes one cycle.
- R8: An offered request whose `pfReady` is low stays offered with the same `pfLine` in the next cycle, unless a new miss arrives in that cycle.
- R9: A miss arriving while a burst is in progress discards the unissued remainder of that burst and starts the new one. A request accepted in the same cycle still counts.
- R10: Each stream number keeps its own history, so misses on one stream do not change the pattern detection of another.
- R11: Line arithmetic wraps modulo 2^LINE_W, so negative strides and strides that cross address zero work.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | A demand miss is presented this cycle |
| accLine | input | LINE_W | Line address of the miss |
| accStream | input | $clog2(STREAMS) | Stream number of the miss |
| pfValid | output | 1 | A prefetch request is offered |
| pfReady | input | 1 | The request is taken this cycle |
| pfLine | output | LINE_W | Line address of the offered request |
| pfDone | input | 1 | One outstanding request has completed |

## Verification
The bench builds the block with a 20-bit line address, 4 streams, a look-ahead depth of 3 and a cap of 5. With a 20-bit address, a descending stride crosses line zero within a few misses. A cap of 5 is reached after two bursts, so the stall and release on `pfDone` come up early and often. With a depth of 3, a new miss arriving in the middle of a burst lands while part of the burst is still unissued, which shows the replacement behaviour. A behavioural queue model runs through directed phases and then a long pseudo-random phase with back-pressure, and it is compared against the ports in every cycle.

// File: rtl/pf_pkg.sv
package pf_pkg;
  // Strobes sent from the issue control to the issue datapath
  typedef struct packed {
    logic load;     // start a new burst from the table's proposal
    logic advance;  // step to the next burst line (issued or discarded)
    logic issue;    // request accepted at the port this cycle
  } pfStrobes_t;
endpackage

// File: rtl/pf_stream_table.sv
module pf_stream_table #(
  parameter int LINE_W  = 32,
  parameter int STREAMS = 8,
  parameter int DEGREE  = 4,
  localparam int SID_W  = $clog2(STREAMS),
  localparam int LEN_W  = $clog2(DEGREE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accValid,
  input  logic [LINE_W-1:0] accLine,
  input  logic [SID_W-1:0]  accStream,
  output logic [LINE_W-1:0] burstStep,
  output logic [LEN_W-1:0]  burstLen
);
  logic [LINE_W-1:0] entAddr  [STREAMS];
  logic [LINE_W-1:0] entDelta [STREAMS];
  logic [1:0]        entConf  [STREAMS];
  logic [STREAMS-1:0] entValid;

  logic              hit;
  logic [LINE_W-1:0] delta;
  logic              match;
  logic [1:0]        newConf;
  logic [LINE_W-1:0] storeDelta;
  logic              strideOn;

  always_comb begin
    hit        = entValid[accStream];
    delta      = accLine - entAddr[accStream];
    match      = hit && (delta == entDelta[accStream]) && (delta != '0);
    if (!match)                          newConf = 2'd0;
    else if (entConf[accStream] == 2'd3) newConf = 2'd3;
    else                                 newConf = entConf[accStream] + 2'd1;
    storeDelta = hit ? delta : '0;
    strideOn   = newConf[1];
    burstStep  = strideOn ? delta : LINE_W'(1);
    burstLen   = strideOn ? LEN_W'(DEGREE) : LEN_W'(1);
  end

  for (genvar g = 0; g < STREAMS; g++) begin : g_entry
    logic sel;
    assign sel = accValid && (accStream == SID_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entValid[g] <= 1'b0;
        entAddr[g]  <= '0;
        entDelta[g] <= '0;
        entConf[g]  <= 2'd0;
      end else if (sel) begin
        entValid[g] <= 1'b1;
        entAddr[g]  <= accLine;
        entDelta[g] <= storeDelta;
        entConf[g]  <= newConf;
      end
    end
  end
endmodule

// File: rtl/pf_issue_ctrl.sv
module pf_issue_ctrl #(
  parameter int DEGREE = 4,
  localparam int LEN_W = $clog2(DEGREE + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    newMiss,
  input  logic [LEN_W-1:0]        burstLen,
  input  logic                    dupHit,
  input  logic                    capFull,
  input  logic                    pfReady,
  output logic                    pfValid,
  output pf_pkg::pfStrobes_t      stb
);
  logic [LEN_W-1:0] leftCnt;
  logic             active;

  always_comb begin
    active      = (leftCnt != '0);
    pfValid     = active && !dupHit && !capFull;
    stb.load    = newMiss;
    stb.issue   = pfValid && pfReady;
    stb.advance = stb.issue || (active && dupHit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               leftCnt <= '0;
    else if (stb.load)        leftCnt <= burstLen;
    else if (stb.advance)     leftCnt <= leftCnt - LEN_W'(1);
  end
endmodule

// File: rtl/pf_issue_dp.sv
module pf_issue_dp #(
  parameter int LINE_W = 32,
  parameter int CAP    = 16,
  localparam int CNT_W = $clog2(CAP + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pf_pkg::pfStrobes_t stb,
  input  logic [LINE_W-1:0]  missLine,
  input  logic [LINE_W-1:0]  burstStep,
  input  logic               pfDone,
  output logic [LINE_W-1:0]  pfLine,
  output logic               dupHit,
  output logic               capFull
);
  logic [LINE_W-1:0] curLine, stepReg, lastIssued;
  logic              lastValid;
  logic [CNT_W-1:0]  outCnt;
  logic              retire;

  always_comb begin
    pfLine  = curLine;
    dupHit  = lastValid && (curLine == lastIssued);
    capFull = (outCnt >= CNT_W'(CAP));
    retire  = pfDone && (outCnt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curLine    <= '0;
      stepReg    <= '0;
      lastIssued <= '0;
      lastValid  <= 1'b0;
      outCnt     <= '0;
    end else begin
      if (stb.load) begin
        curLine <= missLine + burstStep;
        stepReg <= burstStep;
      end else if (stb.advance) begin
        curLine <= curLine + stepReg;
      end
      if (stb.issue) begin
        lastIssued <= curLine;
        lastValid  <= 1'b1;
      end
      if (stb.issue && !retire)      outCnt <= outCnt + CNT_W'(1);
      else if (!stb.issue && retire) outCnt <= outCnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int LINE_W  = 32,
  parameter int STREAMS = 8,
  parameter int DEGREE  = 4,
  parameter int CAP     = 16,
  localparam int SID_W  = $clog2(STREAMS),
  localparam int LEN_W  = $clog2(DEGREE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accValid,
  input  logic [LINE_W-1:0] accLine,
  input  logic [SID_W-1:0]  accStream,
  output logic              pfValid,
  input  logic              pfReady,
  output logic [LINE_W-1:0] pfLine,
  input  logic              pfDone
);
  logic [LINE_W-1:0]  burstStep;
  logic [LEN_W-1:0]   burstLen;
  logic               dupHit, capFull;
  pf_pkg::pfStrobes_t stb;

  pf_stream_table #(.LINE_W(LINE_W), .STREAMS(STREAMS), .DEGREE(DEGREE)) u_table (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accLine(accLine),
    .accStream(accStream), .burstStep(burstStep), .burstLen(burstLen)
  );

  pf_issue_ctrl #(.DEGREE(DEGREE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .newMiss(accValid), .burstLen(burstLen),
    .dupHit(dupHit), .capFull(capFull), .pfReady(pfReady),
    .pfValid(pfValid), .stb(stb)
  );

  pf_issue_dp #(.LINE_W(LINE_W), .CAP(CAP)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .missLine(accLine),
    .burstStep(burstStep), .pfDone(pfDone), .pfLine(pfLine),
    .dupHit(dupHit), .capFull(capFull)
  );
endmodule

// File: rtl/stride_prefetcher_chk.sv
module stride_prefetcher_chk #(
  parameter int LINE_W = 32,
  parameter int CAP    = 16,
  localparam int CNT_W = $clog2(CAP + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accValid,
  input logic              pfValid,
  input logic              pfReady,
  input logic [LINE_W-1:0] pfLine,
  input logic              pfDone
);
  logic [CNT_W-1:0] shadowCnt;
  logic             take, drop;
  assign take = pfValid && pfReady;
  assign drop = pfDone && (shadowCnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            shadowCnt <= '0;
    else if (take && !drop) shadowCnt <= shadowCnt + CNT_W'(1);
    else if (!take && drop) shadowCnt <= shadowCnt - CNT_W'(1);
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !pfValid);

  // R6
  cap_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pfValid |-> (shadowCnt < CNT_W'(CAP)));

  // R8
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pfValid && !pfReady && !accValid) |=> (pfValid && $stable(pfLine)));

  // R7
  no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pfValid && pfReady) |=> !(pfValid && (pfLine == $past(pfLine))));
endmodule

bind stride_prefetcher stride_prefetcher_chk #(.LINE_W(LINE_W), .CAP(CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .accValid(accValid), .pfValid(pfValid),
  .pfReady(pfReady), .pfLine(pfLine), .pfDone(pfDone)
);

// File: tb/test_stride_prefetcher.sv
module test_stride_prefetcher;
  localparam int PERIOD  = 10;
  localparam int LW      = 20;
  localparam int NSTR    = 4;
  localparam int DEG     = 3;
  localparam int NCAP    = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          accValid = 1'b0;
  logic [LW-1:0] accLine = '0;
  logic [1:0]    accStream = '0;
  logic          pfValid;
  logic          pfReady = 1'b0;
  logic [LW-1:0] pfLine;
  logic          pfDone = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  stride_prefetcher #(.LINE_W(LW), .STREAMS(NSTR), .DEGREE(DEG), .CAP(NCAP)) i_stride_prefetcher (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accLine(accLine),
    .accStream(accStream), .pfValid(pfValid), .pfReady(pfReady),
    .pfLine(pfLine), .pfDone(pfDone)
  );

  int checks = 0;
  int fails  = 0;
  string curReq = "R1";

  // behavioural model state
  logic [LW-1:0] pend[$];
  logic [LW-1:0] mAddr [NSTR];
  logic [LW-1:0] mDelta[NSTR];
  int            mConf [NSTR];
  bit            mVal  [NSTR];
  logic [LW-1:0] li = '0;
  bit            liV = 0;
  int            cnt = 0;

  task automatic check(input bit ok, input string what, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit aV, input logic [LW-1:0] aL, input int aS, input bit rdy, input bit dn);
    logic [LW-1:0] head = '0;
    logic [LW-1:0] d, nx;
    bit dup = 0, expV = 0, issue, hit, match;
    int c;
    @(negedge clk);
    if (pend.size() > 0) begin
      head = pend[0];
      dup  = liV && (head == li);
      expV = !dup && (cnt < NCAP);
    end
    check(pfValid === expV, "pfValid", LW'(pfValid), LW'(expV));
    if (expV) check(pfLine === head, "pfLine", pfLine, head);
    accValid  = aV;
    accLine   = aL;
    accStream = 2'(aS);
    pfReady   = rdy;
    pfDone    = dn;
    issue = expV && rdy;
    c = cnt + (issue ? 1 : 0) - ((dn && cnt > 0) ? 1 : 0);
    cnt = c;
    if (issue) begin li = head; liV = 1; end
    if (issue || (pend.size() > 0 && dup)) void'(pend.pop_front());
    if (aV) begin
      pend.delete();
      hit   = mVal[aS];
      d     = aL - mAddr[aS];
      match = hit && (d == mDelta[aS]) && (d != '0);
      mConf[aS] = match ? ((mConf[aS] == 3) ? 3 : mConf[aS] + 1) : 0;
      if (mConf[aS] >= 2) begin
        nx = aL;
        for (int k = 1; k <= DEG; k++) begin nx = nx + d; pend.push_back(nx); end
      end else begin
        pend.push_back(aL + LW'(1));
      end
      mDelta[aS] = hit ? d : '0;
      mAddr[aS]  = aL;
      mVal[aS]   = 1;
    end
  endtask

  task automatic miss(input logic [LW-1:0] aL, input int aS);
    cyc(1, aL, aS, 1, 0);
  endtask

  task automatic idle(input int n, input bit rdy, input bit dn);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, rdy, dn);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSTR; s++) begin mAddr[s] = '0; mDelta[s] = '0; mConf[s] = 0; mVal[s] = 0; end
    // R1: quiet in reset
    repeat (3) begin
      @(negedge clk);
      check(pfValid === 1'b0, "pfValid in reset", LW'(pfValid), '0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(2, 1, 0);

    // R2: single next-line request
    curReq = "R2";
    miss(20'h00100, 0);
    idle(3, 1, 1);

    // R3/R4: stride 8 on stream 1 gains confidence, then a broken delta resets it
    curReq = "R4";
    miss(20'h00200, 1); idle(3, 1, 1);
    miss(20'h00208, 1); idle(3, 1, 1);
    miss(20'h00210, 1); idle(3, 1, 1);
    miss(20'h00218, 1); idle(5, 1, 1);
    miss(20'h00220, 1); idle(5, 1, 1);
    curReq = "R3";
    miss(20'h00224, 1); idle(3, 1, 1);
    miss(20'h00228, 1); idle(3, 1, 1);

    // R11: descending stride crossing line zero
    curReq = "R11";
    miss(20'h00008, 2); idle(2, 1, 1);
    miss(20'h00004, 2); idle(2, 1, 1);
    miss(20'h00000, 2); idle(2, 1, 1);
    miss(20'hFFFFC, 2); idle(5, 1, 1);

    // R5 and R7: zero delta falls back, repeated line is suppressed
    curReq = "R5";
    miss(20'h00500, 3); idle(3, 1, 1);
    curReq = "R7";
    miss(20'h00500, 3); idle(3, 1, 1);
    miss(20'h00500, 3); idle(3, 1, 1);

    // R6: fill to the cap without completions, then release
    curReq = "R6";
    miss(20'h01000, 0); miss(20'h01010, 0); miss(20'h01020, 0); idle(4, 1, 0);
    miss(20'h01030, 0); idle(4, 1, 0);
    miss(20'h01040, 0); idle(4, 1, 0);
    idle(3, 1, 1);
    idle(6, 1, 1);

    // R8: back-pressure holds the offer
    curReq = "R8";
    miss(20'h02000, 1); miss(20'h02004, 1); miss(20'h02008, 1); miss(20'h0200C, 1);
    idle(4, 0, 1);
    idle(5, 1, 1);

    // R9: new miss replaces an unfinished burst
    curReq = "R9";
    miss(20'h02010, 1);
    cyc(0, '0, 0, 1, 1);
    miss(20'h03000, 2);
    idle(4, 1, 1);

    // R10: interleaved streams keep their own history
    curReq = "R10";
    for (int i = 0; i < 5; i++) begin
      miss(20'h04000 + LW'(i * 3), 0);
      cyc(0, '0, 0, 1, 1);
      miss(20'h05000 + LW'(i * 7), 3);
      idle(4, 1, 1);
    end

    // mixed pseudo-random traffic
    curReq = "R4";
    for (int i = 0; i < 4000; i++) begin
      int s = $urandom % NSTR;
      bit a = ($urandom % 4) == 0;
      logic [LW-1:0] base = LW'(s * 20'h10000);
      logic [LW-1:0] ln = base + LW'(((i / 8) % 64) * (s + 1)) + LW'(($urandom % 8 == 0) ? 5 : 0);
      cyc(a, ln, s, ($urandom % 4) != 0, ($urandom % 3) == 0);
    end
    idle(20, 1, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule